// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into a queue of received characters. It counts a 16x oversampling enable that comes from an external rate generator. A falling edge on the synchronised line starts a frame, which the block confirms at mid-bit. Each bit is decided by a three-sample majority vote, and the finished character is pushed into a 16-entry first-in first-out queue. Every queue entry carries its own parity-error and framing-error tag. The block keeps a live count of tagged entries beside the fill level.

The consumer reads the head of the queue directly from the output pins and removes it with a one-cycle pop pulse. Six condition outputs are available, each gated by its own enable: data waiting, queue full, line break, entries with errors, character lost, and idle timeout. A DMA request stays asserted for as long as the queue holds data. The synchronised line level is also brought out so that software can inspect the wire during a break.

Top module: `serial_rx_queue`

## Requirements
- R1: Frame format is chosen by `cfg_len8` (1 = 8 data bits, 0 = 7), `cfg_stop2` (1 = two stop bits) and `cfg_par` (2'b01 even, 2'b10 odd, 2'b00 or 2'b11 no parity bit). Data bits arrive least significant bit first. A 7-bit character is stored with bit 7 cleared.
- R2: An entry is tagged with a parity error when the parity bit does not give the selected parity over the data bits. It is tagged with a framing error when any stop bit is sampled low.
- R3: After a framing error, the break condition is raised once the line has stayed low for more than one frame length, that is frame_bits*16 oversample ticks. It drops within three clocks after the pin returns high.
- R4: The queue holds 16 entries. `fill` gives the number held. `rd_data`, `rd_perr` and `rd_ferr` show the oldest entry, and `pop` removes that entry. A pop while the queue is empty has no effect.
- R5: `err_cnt` equals the number of held entries with either error tag set. It rises on such a push and falls on such a pop.
- R6: A character that completes while 16 entries are held is discarded and the queue contents are unchanged. This sets the lost-character flag, which is held until the next successful pop.
- R7: A low level seen at a tick starts a frame only if the line is still low 8 ticks later; otherwise the receiver returns to idle with nothing queued. Each bit value is the majority of the samples taken at ticks 7, 8 and 9 of that bit.
- R8: The timeout flag sets when the receiver has been idle with the line high for frame_bits*24 ticks (1.5 frames) while the queue is non-empty. Any pop clears it.
- R9: `irq_ready` (queue non-empty), `irq_full` (16 held), `irq_break`, `irq_err` (`err_cnt` non-zero), `irq_ovr` and `irq_tmo` are each gated by their own enable. `dma_req` is ungated and equals "queue non-empty".
- R10: `line_lvl` shows `rxd` through a two-flop synchroniser, with a latency of two clock edges.
- R11: After reset, `fill` and `err_cnt` are 0, every condition output and `dma_req` are 0, and `line_lvl` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line input, idles high |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par | input | 2 | Parity: 01 even, 10 odd, else none |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| ien_ready | input | 1 | Enable for data-waiting output |
| ien_full | input | 1 | Enable for queue-full output |
| ien_break | input | 1 | Enable for break output |
| ien_err | input | 1 | Enable for error-entry output |
| ien_ovr | input | 1 | Enable for lost-character output |
| ien_tmo | input | 1 | Enable for timeout output |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity-error tag |
| rd_ferr | output | 1 | Head entry framing-error tag |
| fill | output | 5 | Number of entries held |
| err_cnt | output | 5 | Number of held entries with an error tag |
| irq_ready | output | 1 | Data waiting |
| irq_full | output | 1 | Queue full |
| irq_break | output | 1 | Break on the line |
| irq_err | output | 1 | Error entries held |
| irq_ovr | output | 1 | Character lost |
| irq_tmo | output | 1 | Idle timeout with data waiting |
| dma_req | output | 1 | Transfer request while data is held |
| line_lvl | output | 1 | Synchronised line level |

## Verification
A wrong queue pointer or counter shows up at `fill`, `err_cnt` or `dma_req` one clock after the push or pop that caused it. It also shows at `rd_data` at the next pop. A framing state machine that slips a bit position or misreads a stop bit produces a wrong character or a wrong tag at the head within one frame time. The break and timeout counters are checked from both sides of their thresholds, so a miscounted limit shows at `irq_break` or `irq_tmo` within one frame time of where the flag should have changed.

// File: rtl/srq_pkg.sv
package srq_pkg;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_char_t;

  function automatic logic par_on(input logic [1:0] pmode);
    return (pmode == PAR_EVEN) || (pmode == PAR_ODD);
  endfunction

  // start + data + optional parity + stop bits
  function automatic logic [3:0] frame_bits(input logic len8, input logic [1:0] pmode,
                                            input logic stop2);
    return 4'd1 + (len8 ? 4'd8 : 4'd7) + (par_on(pmode) ? 4'd1 : 4'd0) + (stop2 ? 4'd2 : 4'd1);
  endfunction

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic parity_bad(input logic [7:0] data, input logic [1:0] pmode,
                                      input logic pbit);
    logic x;
    x = (^data) ^ pbit;
    if (pmode == PAR_EVEN) return x;
    if (pmode == PAR_ODD)  return ~x;
    return 1'b0;
  endfunction

endpackage

// File: rtl/srq_framer.sv
module srq_framer
  import srq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       len8,
  input  logic [1:0] pmode,
  input  logic       stop2,
  output logic       done,
  output rx_char_t   chr,
  output logic       idle
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] S_MID = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OSR - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} st_t;

  st_t            st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]     smp;
  logic [2:0]     bidx;
  logic           sidx;
  logic [7:0]     shreg;
  logic           pbit;
  logic           ferr_acc;

  logic       vote;
  logic [2:0] last_idx;
  logic [7:0] data_fin;

  assign vote     = maj3(smp);
  assign last_idx = len8 ? 3'd7 : 3'd6;
  assign data_fin = len8 ? shreg : {1'b0, shreg[7:1]};
  assign idle     = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      smp      <= '1;
      bidx     <= '0;
      sidx     <= 1'b0;
      shreg    <= '0;
      pbit     <= 1'b0;
      ferr_acc <= 1'b0;
      done     <= 1'b0;
      chr      <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!line) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == S_LO)  smp[0] <= line;
          if (cnt == S_MID) smp[1] <= line;
          if (cnt == S_HI)  smp[2] <= line;
          if (st == ST_START && cnt == S_MID && line) begin
            st <= ST_IDLE;
          end else if (cnt == S_END) begin
            cnt <= '0;
            unique case (st)
              ST_START: begin
                st       <= ST_DATA;
                bidx     <= '0;
                ferr_acc <= 1'b0;
              end
              ST_DATA: begin
                shreg <= {vote, shreg[7:1]};
                bidx  <= bidx + 1'b1;
                sidx  <= 1'b0;
                if (bidx == last_idx) st <= par_on(pmode) ? ST_PAR : ST_STOP;
              end
              ST_PAR: begin
                pbit <= vote;
                st   <= ST_STOP;
              end
              ST_STOP: begin
                if (stop2 && !sidx) begin
                  sidx     <= 1'b1;
                  ferr_acc <= ferr_acc | ~vote;
                end else begin
                  st        <= ST_IDLE;
                  done      <= 1'b1;
                  chr.data  <= data_fin;
                  chr.ferr  <= ferr_acc | ~vote;
                  chr.perr  <= parity_bad(data_fin, pmode, pbit);
                end
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/srq_watch.sv
module srq_watch #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       rx_idle,
  input  logic       done,
  input  logic       done_ferr,
  input  logic       pop_ok,
  input  logic       empty,
  input  logic [3:0] fbits,
  output logic       brk,
  output logic       tmo
);
  localparam int BW = $clog2(15*OSR + 2) + 1;
  localparam int TW = $clog2(15*(OSR + OSR/2) + 1) + 1;

  logic [BW-1:0] bcnt, brk_lim;
  logic [TW-1:0] tcnt, tmo_lim;
  logic          armed;

  assign brk_lim = BW'(int'(fbits) * OSR);
  assign tmo_lim = TW'(int'(fbits) * (OSR + OSR/2));

  // break: low for more than one frame after a framing error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      bcnt  <= '0;
      brk   <= 1'b0;
    end else if (line) begin
      armed <= 1'b0;
      bcnt  <= '0;
      brk   <= 1'b0;
    end else begin
      if (done && done_ferr) armed <= 1'b1;
      if (armed && tick && bcnt <= brk_lim) bcnt <= bcnt + 1'b1;
      if (armed && bcnt > brk_lim) brk <= 1'b1;
    end
  end

  // idle timeout with data waiting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      tmo  <= 1'b0;
    end else begin
      if (!rx_idle || pop_ok) tcnt <= '0;
      else if (tick && tcnt < tmo_lim) tcnt <= tcnt + 1'b1;
      if (pop_ok) tmo <= 1'b0;
      else if (tcnt == tmo_lim && !empty) tmo <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int OSR   = 16,
  localparam int CW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          cfg_len8,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_stop2,
  input  logic          ien_ready,
  input  logic          ien_full,
  input  logic          ien_break,
  input  logic          ien_err,
  input  logic          ien_ovr,
  input  logic          ien_tmo,
  input  logic          pop,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] err_cnt,
  output logic          irq_ready,
  output logic          irq_full,
  output logic          irq_break,
  output logic          irq_err,
  output logic          irq_ovr,
  output logic          irq_tmo,
  output logic          dma_req,
  output logic          line_lvl
);
  localparam int EW = $bits(rx_char_t);

  logic       sync1, sync2;
  logic       chr_done, rx_idle;
  rx_char_t   chr, head;
  logic [EW-1:0] head_raw;
  logic       q_full, q_empty;
  logic       push_ok, pop_ok, ovr_evt;
  logic       ovr_flag, brk_flag, tmo_flag;
  logic       push_err, pop_err;
  logic [3:0] fbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
    end
  end
  assign line_lvl = sync2;

  assign fbits = frame_bits(cfg_len8, cfg_par, cfg_stop2);

  srq_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(sync2),
    .len8(cfg_len8), .pmode(cfg_par), .stop2(cfg_stop2),
    .done(chr_done), .chr(chr), .idle(rx_idle)
  );

  assign push_ok = chr_done && !q_full;
  assign ovr_evt = chr_done && q_full;
  assign pop_ok  = pop && !q_empty;

  srq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(chr_done), .din(chr),
    .pop(pop), .dout(head_raw), .count(fill), .full(q_full), .empty(q_empty)
  );

  assign head    = rx_char_t'(head_raw);
  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;

  assign push_err = push_ok && (chr.perr || chr.ferr);
  assign pop_err  = pop_ok && (head.perr || head.ferr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      ovr_flag <= 1'b0;
    end else begin
      case ({push_err, pop_err})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
      if (ovr_evt)     ovr_flag <= 1'b1;
      else if (pop_ok) ovr_flag <= 1'b0;
    end
  end

  srq_watch #(.OSR(OSR)) u_watch (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(sync2),
    .rx_idle(rx_idle && sync2), .done(chr_done), .done_ferr(chr.ferr),
    .pop_ok(pop_ok), .empty(q_empty), .fbits(fbits),
    .brk(brk_flag), .tmo(tmo_flag)
  );

  assign irq_ready = ien_ready && !q_empty;
  assign irq_full  = ien_full  && q_full;
  assign irq_break = ien_break && brk_flag;
  assign irq_err   = ien_err   && (err_cnt != '0);
  assign irq_ovr   = ien_ovr   && ovr_flag;
  assign irq_tmo   = ien_tmo   && tmo_flag;
  assign dma_req   = !q_empty;

endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] err_cnt,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          ovr_evt,
  input logic          ovr_flag,
  input logic          brk_flag,
  input logic          tmo_flag,
  input logic          line_lvl,
  input logic          dma_req
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));  // R4
  AST_ERR_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= fill);  // R5
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> fill == $past(fill) + 1'b1);  // R4
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt && !pop_ok |=> fill == $past(fill));  // R6
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag);  // R6
  AST_TMO_POPCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !tmo_flag);  // R8
  AST_BRK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl |=> !brk_flag);  // R3
  AST_DMA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req == (fill != '0));  // R9
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fill), .err_cnt(err_cnt),
  .push_ok(push_ok), .pop_ok(pop_ok), .ovr_evt(ovr_evt), .ovr_flag(ovr_flag),
  .brk_flag(brk_flag), .tmo_flag(tmo_flag), .line_lvl(line_lvl), .dma_req(dma_req)
);

// File: tb/serial_rx_queue_tb_top.sv
module serial_rx_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len8 = 1'b1, cfg_stop2 = 1'b0;
  logic [1:0] cfg_par = 2'b00;
  logic ien_ready = 1, ien_full = 1, ien_break = 1, ien_err = 1, ien_ovr = 1, ien_tmo = 1;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr;
  logic [4:0] fill, err_cnt;
  logic irq_ready, irq_full, irq_break, irq_err, irq_ovr, irq_tmo, dma_req, line_lvl;

  int n_checks = 0;
  int n_fails  = 0;

  serial_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .ien_ready(ien_ready), .ien_full(ien_full), .ien_break(ien_break),
    .ien_err(ien_err), .ien_ovr(ien_ovr), .ien_tmo(ien_tmo), .pop(pop),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .fill(fill), .err_cnt(err_cnt),
    .irq_ready(irq_ready), .irq_full(irq_full), .irq_break(irq_break),
    .irq_err(irq_err), .irq_ovr(irq_ovr), .irq_tmo(irq_tmo),
    .dma_req(dma_req), .line_lvl(line_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 tick16 = 1'b1;
      @(posedge clk);
      #1 tick16 = 1'b0;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rxd = 1'b1; pop = 1'b0;
    cfg_len8 = 1'b1; cfg_par = 2'b00; cfg_stop2 = 1'b0;
    {ien_ready, ien_full, ien_break, ien_err, ien_ovr, ien_tmo} = '1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    wait_clk(BIT_CLKS);
  endtask

  // serialise one frame in the current format
  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [7:0] v;
    logic pb;
    int nb;
    nb = cfg_len8 ? 8 : 7;
    v  = cfg_len8 ? d : {1'b0, d[6:0]};
    pb = (cfg_par == 2'b01) ? ^v : ~^v;
    if (bad_par) pb = ~pb;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(v[i]);
    if (cfg_par == 2'b01 || cfg_par == 2'b10) drive_bit(pb);
    drive_bit(~bad_stop);
    if (cfg_stop2) drive_bit(1'b1);
    rxd = 1'b1;
    wait_clk(32);
  endtask

  task automatic pop_one();
    pop = 1'b1;
    wait_clk(1);
    pop = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11", "fill", fill, 0);
    chk("R11", "err_cnt", err_cnt, 0);
    chk("R11", "irqs", {irq_ready, irq_full, irq_break, irq_err, irq_ovr, irq_tmo}, 0);
    chk("R11", "dma_req", dma_req, 0);
    chk("R11", "line_lvl", line_lvl, 1);
  endtask

  task automatic t_line();
    do_reset();
    rxd = 1'b0;
    wait_clk(1);
    chk("R10", "line after 1 edge", line_lvl, 1);
    wait_clk(1);
    chk("R10", "line after 2 edges", line_lvl, 0);
    rxd = 1'b1;
    wait_clk(2);
    chk("R10", "line high again", line_lvl, 1);
  endtask

  task automatic t_formats();
    logic [7:0] exp_d [5];
    do_reset();
    cfg_len8 = 1; cfg_par = 2'b00; cfg_stop2 = 0; send(8'hA5, 0, 0); exp_d[0] = 8'hA5;
    cfg_len8 = 0; cfg_par = 2'b01; cfg_stop2 = 1; send(8'hDB, 0, 0); exp_d[1] = 8'h5B;
    cfg_len8 = 1; cfg_par = 2'b10; cfg_stop2 = 0; send(8'h3C, 0, 0); exp_d[2] = 8'h3C;
    cfg_len8 = 0; cfg_par = 2'b11; cfg_stop2 = 1; send(8'hFF, 0, 0); exp_d[3] = 8'h7F;
    cfg_len8 = 1; cfg_par = 2'b01; cfg_stop2 = 1; send(8'h81, 0, 0); exp_d[4] = 8'h81;
    chk("R4", "fill after 5 formats", fill, 5);
    chk("R9", "dma_req with data", dma_req, 1);
    chk("R9", "irq_ready with data", irq_ready, 1);
    ien_ready = 1'b0;
    wait_clk(1);
    chk("R9", "irq_ready masked", irq_ready, 0);
    ien_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk("R1", "format data", rd_data, exp_d[i]);
      chk("R2", "clean flags", {rd_perr, rd_ferr}, 0);
      pop_one();
    end
    chk("R4", "fill drained", fill, 0);
    chk("R9", "dma_req empty", dma_req, 0);
  endtask

  task automatic t_errors();
    do_reset();
    cfg_len8 = 1; cfg_par = 2'b01; cfg_stop2 = 0;
    send(8'h11, 0, 0);
    send(8'h22, 1, 0);
    send(8'h33, 0, 1);
    send(8'h44, 1, 1);
    chk("R4", "fill", fill, 4);
    chk("R5", "err_cnt", err_cnt, 3);
    chk("R9", "irq_err", irq_err, 1);
    chk("R2", "good entry", {rd_perr, rd_ferr, rd_data}, {2'b00, 8'h11});
    pop_one();
    chk("R5", "err_cnt after clean pop", err_cnt, 3);
    chk("R2", "parity entry", {rd_perr, rd_ferr, rd_data}, {2'b10, 8'h22});
    pop_one();
    chk("R5", "err_cnt after pop", err_cnt, 2);
    chk("R2", "framing entry", {rd_perr, rd_ferr, rd_data}, {2'b01, 8'h33});
    pop_one();
    chk("R2", "both entry", {rd_perr, rd_ferr, rd_data}, {2'b11, 8'h44});
    pop_one();
    chk("R5", "err_cnt drained", err_cnt, 0);
    chk("R9", "irq_err cleared", irq_err, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), 0, 0);
    chk("R6", "fill held at 16", fill, 16);
    chk("R9", "irq_full", irq_full, 1);
    chk("R6", "overrun flag", irq_ovr, 1);
    ien_ovr = 1'b0;
    wait_clk(1);
    chk("R9", "irq_ovr masked", irq_ovr, 0);
    ien_ovr = 1'b1;
    wait_clk(1);
    for (int i = 0; i < 16; i++) begin
      chk("R6", "kept entry", rd_data, (i * 7 + 1) & 8'hFF);
      pop_one();
      if (i == 0) chk("R6", "overrun cleared by pop", irq_ovr, 0);
    end
    chk("R4", "fill empty", fill, 0);
    pop_one();
    chk("R4", "pop on empty ignored", fill, 0);
    chk("R5", "err_cnt after empty pop", err_cnt, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    send(8'h5A, 0, 0);
    chk("R8", "no timeout early", irq_tmo, 0);
    wait_clk(10 * BIT_CLKS);
    chk("R8", "no timeout at 1 frame", irq_tmo, 0);
    wait_clk(10 * BIT_CLKS);
    chk("R8", "timeout at 2 frames", irq_tmo, 1);
    ien_tmo = 1'b0;
    wait_clk(1);
    chk("R9", "irq_tmo masked", irq_tmo, 0);
    ien_tmo = 1'b1;
    pop_one();
    chk("R8", "pop clears timeout", irq_tmo, 0);
    wait_clk(25 * BIT_CLKS);
    chk("R8", "no timeout when empty", irq_tmo, 0);
  endtask

  task automatic t_break();
    do_reset();
    rxd = 1'b0;
    wait_clk(16 * BIT_CLKS);
    chk("R3", "no break before frame length", irq_break, 0);
    wait_clk(10 * BIT_CLKS);
    chk("R3", "break after frame length", irq_break, 1);
    chk("R3", "line reads low", line_lvl, 0);
    rxd = 1'b1;
    wait_clk(4);
    chk("R3", "break drops on high", irq_break, 0);
  endtask

  task automatic t_glitch();
    do_reset();
    rxd = 1'b0;
    wait_clk(2 * TICK_DIV);
    rxd = 1'b1;
    wait_clk(12 * BIT_CLKS);
    chk("R7", "short low pulse ignored", fill, 0);
    send(8'hC3, 0, 0);
    chk("R7", "valid frame after glitch", rd_data, 8'hC3);
  endtask

  initial begin
    t_reset();
    t_line();
    t_formats();
    t_errors();
    t_overrun();
    t_timeout();
    t_break();
    t_glitch();
    summary();
    $finish;
  end

endmodule